// File: doc/BRIEF.md
# Combined LFSR and Shift-Register Pattern Generator

This block produces pseudo-exhaustive test vectors for a combinational circuit whose outputs each depend on only a few of its inputs. The leading stages of one register chain form an autonomous LFSR with a configurable feedback tap set. The trailing stages form a plain shift register with no feedback, fed from the last LFSR stage. The tail lines therefore carry delayed copies of that last LFSR bit. With the default settings there are three LFSR stages and one tail stage, and the block drives four lines for a circuit in which every output depends on at most two inputs.

One seed seldom reaches full pseudo-exhaustive coverage, so the whole chain can be reloaded at runtime. A test controller loads a seed, steps the generator and watches the period pulse, which marks each completed LFSR cycle. It then loads the next seed. Seed selection and response compaction are handled outside the block.

Top module: `lfsr_sr_pattern_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `pattern` equals the parameter `RESET_SEED` (default 4'b0111) and `period_done` is 0.
- R2: On a step, the new first line (`pattern[N-1]`, x1) is the XOR of the old values of the stages selected by `TAP_MASK`. The default taps x2 and x3 are `pattern[N-2]` and `pattern[N-3]`.
- R3: On a step, every stage other than x1 takes the old value of the stage before it. This includes the tail: `pattern[N-2:0]` becomes the old `pattern[N-1:1]`.
- R4: With the defaults and starting from 0111, seven steps give 0011, 1001, 0100, 1010, 1101, 1110 and then 0111 again. The chain repeats every 7 steps.
- R5: When neither `step_en` nor `seed_load` is high, `pattern` holds its value.
- R6: When `seed_load` is high, the next `pattern` equals `seed` on all lines, whatever the value of `step_en`.
- R7: A seed whose LFSR field (`seed[N-1 -: LFSR_LEN]`) is all zero loads that field as 0…01 (x3=1 by default). The tail lines still take their seed bits. The LFSR field never reads zero outside reset.
- R8: `period_done` is a one-cycle pulse, visible in the cycle that follows the 7th, 14th, … step counted since the last seed load or reset. A seed load clears the count and forces the pulse low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load `seed` into all stages; has priority over stepping |
| seed | input | N | Seed value, MSB is x1 |
| step_en | input | 1 | Advance the chain by one step |
| pattern | output | N | Test vector, `pattern[N-1]` is x1 and `pattern[0]` is xn |
| period_done | output | 1 | Pulse after each full LFSR period since the last load |

## Verification
The hardest case to create is a seed load that arrives on the exact cycle the period counter would wrap. At that point, a half-counted period and a reload decide the pulse together. The stimulus first runs part of a period. It then reloads and steps six more times, and applies the next load together with `step_en` on what would be the seventh step. The bench expects no pulse there, and a pulse only after seven clean steps from the new seed. A zero LFSR field is also reached only by a deliberate seed. The bench covers it with a tail bit set and with a tail bit clear.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_STEP = 2'd1,
      ACT_LOAD = 2'd2
   } lsg_act_e;

   function automatic lsg_act_e decode_act(input logic load, input logic step);
      if (load)      return ACT_LOAD;
      else if (step) return ACT_STEP;
      else           return ACT_HOLD;
   endfunction

endpackage

// File: rtl/lsg_lfsr_section.sv
module lsg_lfsr_section #(
   parameter int          LEN       = 3,
   parameter logic [LEN-1:0] TAP_MASK  = 3'b110,
   parameter logic [LEN-1:0] RESET_VAL = 3'b011
) (
   input  logic           clk,
   input  logic           rst_n,
   input  lsg_pkg::lsg_act_e act,
   input  logic [LEN-1:0] load_val,
   output logic [LEN-1:0] stages
);
   localparam logic [LEN-1:0] SAFE_VAL = LEN'(1) << (LEN - 1);

   logic           fb;
   logic [LEN-1:0] load_fixed;

   assign fb         = ^(stages & TAP_MASK);
   assign load_fixed = (load_val == '0) ? SAFE_VAL : load_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stages <= RESET_VAL;
      end else begin
         case (act)
            lsg_pkg::ACT_LOAD: stages <= load_fixed;
            lsg_pkg::ACT_STEP: stages <= {stages[LEN-2:0], fb};
            default:           stages <= stages;
         endcase
      end
   end
endmodule

// File: rtl/lsg_shift_tail.sv
module lsg_shift_tail #(
   parameter int             LEN       = 1,
   parameter logic [LEN-1:0] RESET_VAL = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  lsg_pkg::lsg_act_e act,
   input  logic [LEN-1:0] load_val,
   input  logic           din,
   output logic [LEN-1:0] stages
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stages <= RESET_VAL;
      end else begin
         case (act)
            lsg_pkg::ACT_LOAD: stages <= load_val;
            lsg_pkg::ACT_STEP: begin
               stages[0] <= din;
               for (int k = 1; k < LEN; k++) stages[k] <= stages[k-1];
            end
            default: stages <= stages;
         endcase
      end
   end
endmodule

// File: rtl/lsg_period_counter.sv
module lsg_period_counter #(
   parameter int PERIOD = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  lsg_pkg::lsg_act_e act,
   output logic done
);
   localparam int CW = (PERIOD < 2) ? 1 : $clog2(PERIOD);
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         case (act)
            lsg_pkg::ACT_LOAD: begin
               cnt  <= '0;
               done <= 1'b0;
            end
            lsg_pkg::ACT_STEP: begin
               if (cnt == LAST) begin
                  cnt  <= '0;
                  done <= 1'b1;
               end else begin
                  cnt  <= cnt + 1'b1;
                  done <= 1'b0;
               end
            end
            default: done <= 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/lfsr_sr_pattern_gen.sv
module lfsr_sr_pattern_gen #(
   parameter int                         LFSR_LEN   = 3,
   parameter int                         SR_LEN     = 1,
   parameter logic [LFSR_LEN-1:0]        TAP_MASK   = 3'b110,
   parameter logic [LFSR_LEN+SR_LEN-1:0] RESET_SEED = 4'b0111
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         seed_load,
   input  logic [LFSR_LEN+SR_LEN-1:0]   seed,
   input  logic                         step_en,
   output logic [LFSR_LEN+SR_LEN-1:0]   pattern,
   output logic                         period_done
);
   localparam int N_TOTAL = LFSR_LEN + SR_LEN;
   localparam int PERIOD  = (2 ** LFSR_LEN) - 1;

   function automatic logic [N_TOTAL-1:0] flip(input logic [N_TOTAL-1:0] v);
      logic [N_TOTAL-1:0] r;
      for (int j = 0; j < N_TOTAL; j++) r[j] = v[N_TOTAL-1-j];
      return r;
   endfunction

   localparam logic [N_TOTAL-1:0] RST_CHAIN = flip(RESET_SEED);

   // elaboration-time parameter checks
   if (LFSR_LEN < 2 || LFSR_LEN > 24) begin : g_bad_len
      $error("LFSR_LEN must lie in 2..24");
   end
   if (SR_LEN < 0) begin : g_bad_sr
      $error("SR_LEN must not be negative");
   end
   if (!TAP_MASK[LFSR_LEN-1]) begin : g_bad_tap
      $error("TAP_MASK must include the last LFSR stage");
   end
   if (RESET_SEED[N_TOTAL-1 -: LFSR_LEN] == '0) begin : g_bad_rst
      $error("RESET_SEED must have a nonzero LFSR field");
   end

   // chain index 0 is x1
   logic [N_TOTAL-1:0] seed_chain;
   logic [N_TOTAL-1:0] chain;
   lsg_pkg::lsg_act_e  act;

   assign act = lsg_pkg::decode_act(seed_load, step_en);

   for (genvar j = 0; j < N_TOTAL; j++) begin : g_map
      assign seed_chain[j]         = seed[N_TOTAL-1-j];
      assign pattern[N_TOTAL-1-j]  = chain[j];
   end

   lsg_lfsr_section #(
      .LEN      (LFSR_LEN),
      .TAP_MASK (TAP_MASK),
      .RESET_VAL(RST_CHAIN[LFSR_LEN-1:0])
   ) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (act),
      .load_val(seed_chain[LFSR_LEN-1:0]),
      .stages  (chain[LFSR_LEN-1:0])
   );

   if (SR_LEN > 0) begin : g_tail
      lsg_shift_tail #(
         .LEN      (SR_LEN),
         .RESET_VAL(RST_CHAIN[N_TOTAL-1:LFSR_LEN])
      ) u_tail (
         .clk     (clk),
         .rst_n   (rst_n),
         .act     (act),
         .load_val(seed_chain[N_TOTAL-1:LFSR_LEN]),
         .din     (chain[LFSR_LEN-1]),
         .stages  (chain[N_TOTAL-1:LFSR_LEN])
      );
   end

   lsg_period_counter #(
      .PERIOD(PERIOD)
   ) u_period (
      .clk  (clk),
      .rst_n(rst_n),
      .act  (act),
      .done (period_done)
   );
endmodule

// File: rtl/lsg_checker.sv
module lsg_checker #(
   parameter int N = 4,
   parameter int L = 3
) (
   input logic         clk,
   input logic         rst_n,
   input logic         seed_load,
   input logic [N-1:0] seed,
   input logic         step_en,
   input logic [N-1:0] pattern,
   input logic         period_done
);
   a_r3_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !seed_load) |=> pattern[N-2:0] == $past(pattern[N-1:1]));

   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_en && !seed_load) |=> $stable(pattern));

   a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_load && seed[N-1 -: L] != '0) |=> pattern == $past(seed));

   a_r7_zero_seed: assert property (@(posedge clk) disable iff (!rst_n)
      (seed_load && seed[N-1 -: L] == '0) |=> pattern[N-1 -: L] == L'(1));

   a_r7_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      pattern[N-1 -: L] != '0);

   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      period_done |=> !period_done);

   a_r8_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
      seed_load |=> !period_done);
endmodule

bind lfsr_sr_pattern_gen lsg_checker #(
   .N(LFSR_LEN + SR_LEN),
   .L(LFSR_LEN)
) u_lsg_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .seed_load  (seed_load),
   .seed       (seed),
   .step_en    (step_en),
   .pattern    (pattern),
   .period_done(period_done)
);

// File: tb/lfsr_sr_pattern_gen_bench.sv
module lfsr_sr_pattern_gen_bench;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         seed_load = 1'b0;
   logic [N-1:0] seed = '0;
   logic         step_en = 1'b0;
   logic [N-1:0] pattern;
   logic         period_done;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   lfsr_sr_pattern_gen u_lfsr_sr_pattern_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .seed_load  (seed_load),
      .seed       (seed),
      .step_en    (step_en),
      .pattern    (pattern),
      .period_done(period_done)
   );

   // {step_en, expected pattern, expected period_done} after each cycle from 0111
   localparam logic [5:0] VEC [16] = '{
      {1'b1, 4'b0011, 1'b0}, {1'b1, 4'b1001, 1'b0}, {1'b1, 4'b0100, 1'b0},
      {1'b1, 4'b1010, 1'b0}, {1'b1, 4'b1101, 1'b0}, {1'b0, 4'b1101, 1'b0},
      {1'b1, 4'b1110, 1'b0}, {1'b1, 4'b0111, 1'b1}, {1'b0, 4'b0111, 1'b0},
      {1'b1, 4'b0011, 1'b0}, {1'b1, 4'b1001, 1'b0}, {1'b1, 4'b0100, 1'b0},
      {1'b1, 4'b1010, 1'b0}, {1'b1, 4'b1101, 1'b0}, {1'b1, 4'b1110, 1'b0},
      {1'b1, 4'b0111, 1'b1}
   };

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic cyc(input logic ld, input logic [N-1:0] sd, input logic en);
      seed_load = ld;
      seed      = sd;
      step_en   = en;
      @(negedge clk);
      seed_load = 1'b0;
      step_en   = 1'b0;
   endtask

   initial begin
      #400000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] prev;
      repeat (2) @(negedge clk);
      chk("R1 reset pattern", pattern, 4'b0111);
      chk("R1 reset done", {3'b0, period_done}, 4'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pattern after release", pattern, 4'b0111);

      // R4 sequence, R5 hold, R8 pulse, R2 feedback bit
      for (int i = 0; i < 16; i++) begin
         prev = pattern;
         cyc(1'b0, '0, VEC[i][5]);
         chk($sformatf("R4/R5 row %0d pattern", i), pattern, VEC[i][4:1]);
         chk($sformatf("R8 row %0d done", i), {3'b0, period_done}, {3'b0, VEC[i][0]});
         if (VEC[i][5]) begin
            chk($sformatf("R2 row %0d x1", i), {3'b0, pattern[3]}, {3'b0, prev[2] ^ prev[1]});
            chk($sformatf("R3 row %0d shift", i), {1'b0, pattern[2:0]}, {1'b0, prev[3:1]});
         end
      end

      // R6 load with step_en high
      cyc(1'b1, 4'b1000, 1'b1);
      chk("R6 load over step", pattern, 4'b1000);
      chk("R6 done after load", {3'b0, period_done}, 4'b0);
      cyc(1'b0, '0, 1'b1);
      chk("R2/R3 step from 1000", pattern, 4'b0100);

      // R7 zero LFSR field
      cyc(1'b1, 4'b0001, 1'b0);
      chk("R7 zero field tail one", pattern, 4'b0011);
      cyc(1'b1, 4'b0000, 1'b0);
      chk("R7 zero field tail zero", pattern, 4'b0010);

      // R8 period from new seed
      for (int s = 1; s <= 7; s++) begin
         cyc(1'b0, '0, 1'b1);
         chk($sformatf("R8 step %0d after load", s), {3'b0, period_done},
             {3'b0, (s == 7) ? 1'b1 : 1'b0});
      end
      chk("R4 orbit of 001 closes", pattern, 4'b0011);

      // R8 partial count, reload, collision of load with 7th step
      for (int s = 0; s < 4; s++) cyc(1'b0, '0, 1'b1);
      cyc(1'b1, 4'b0111, 1'b0);
      for (int s = 1; s <= 6; s++) begin
         cyc(1'b0, '0, 1'b1);
         chk($sformatf("R8 no pulse step %0d", s), {3'b0, period_done}, 4'b0);
      end
      cyc(1'b1, 4'b0111, 1'b1);
      chk("R8 load on wrap step no pulse", {3'b0, period_done}, 4'b0);
      chk("R6 load on wrap step pattern", pattern, 4'b0111);
      for (int s = 1; s <= 7; s++) begin
         cyc(1'b0, '0, 1'b1);
         chk($sformatf("R8 recount step %0d", s), {3'b0, period_done},
             {3'b0, (s == 7) ? 1'b1 : 1'b0});
      end

      // R1 reset mid-run
      cyc(1'b0, '0, 1'b1);
      cyc(1'b0, '0, 1'b1);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 mid-run reset pattern", pattern, 4'b0111);
      chk("R1 mid-run reset done", {3'b0, period_done}, 4'b0);
      rst_n = 1'b1;
      cyc(1'b0, '0, 1'b1);
      chk("R4 first step after reset", pattern, 4'b0011);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule